// File: doc/BRIEF.md
# Paged Serial-Bus PHY Port Status Window

This block implements the per-port status page of a multi-port serial-bus PHY register map. A base select register elsewhere in the map supplies a page number and a port number. When the page number is zero, an eight-register window at addresses 1000b through 1111b shows the state of the chosen port. The first register holds the two line states, the child/parent role, the filtered connection and bias flags, and the disable control. The second holds the peer speed, the interrupt-enable bit and the fault bit. The other six registers are reserved.

Each port has two slow debounce filters. One turns the raw connect detector into a stable connection flag over roughly 341 ms, and the other turns the raw cable-bias detector into a bias flag over 52 µs. Both limits are parameters in clock cycles. Two reset types are handled. Hardware reset (`rst`) clears everything. A bus reset strobe leaves the connection flag and the disable bit untouched, but marks the child/parent role invalid until tree identification finishes and the peer speed invalid until self identification finishes.

Reads are combinational: data is valid in the same cycle as `rd_en`. The disable bit is the only writable bit, and a write takes effect on the clock edge.

Top module: `port_status_page`

## Requirements
- R1: `rd_data` is 0 unless `rd_en` is high, `sel_page` is 0 and `reg_addr` is 1000b or 1001b. Addresses 1010b through 1111b, and the addresses below 1000b, read 0.
- R2: When `sel_port` is NUM_PORTS or higher, every address reads 0, and a write changes no port's disable bit.
- R3: Address 1000b reads {a_line[1:0], b_line[1:0], child, conn, bias, dis} from bit 7 down to bit 0. Line codes pass through unchanged: 11 means high-Z, 10 means zero, 01 means one, 00 means invalid.
- R4: Address 1001b reads {peer_speed[2:0], int_en, fault, 3'b000} from bit 7 down to bit 0. Speed codes are 000 = S100, 001 = S200 and 010 = S400; all higher codes are invalid.
- R5: The child bit (bit 3 of 1000b) reads 1 whenever the port's filtered connection flag is 0, its disable bit is 1, or its suspend input is 1. Otherwise it follows `child_in`.
- R6: The connection flag takes a new raw level only after that level has been sampled on CON_LIMIT+1 consecutive clock edges. Any change of the raw input restarts the count. Hardware reset clears the flag, and `bus_reset` does not affect it.
- R7: The bias flag follows the same rule as R6, using BIAS_LIMIT+1 consecutive edges.
- R8: A write with page 0, an implemented port and address 1000b loads `wr_data[0]` into that port's disable bit. Other addresses and other bits of `wr_data` are ignored. Hardware reset clears all disable bits, and `bus_reset` keeps them.
- R9: `ch_valid` is 0 after hardware reset and 0 after any edge with `bus_reset` high. It becomes 1 after an edge with `tree_id_done` high and `bus_reset` low. When both strobes are high in the same cycle, bus reset wins.
- R10: `speed_valid` behaves as in R9, using `self_id_done` in place of `tree_id_done`.
- R11: `port_disabled[i]` shows port i's disable bit at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_reset | input | 1 | Bus reset strobe |
| tree_id_done | input | 1 | Tree identification complete strobe |
| self_id_done | input | 1 | Self identification complete strobe |
| sel_page | input | PAGE_W | Page number from the base select register |
| sel_port | input | PORT_W | Port number from the base select register |
| reg_addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Combinational read data |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| line_a | input | 2*NUM_PORTS | Line-state code of the first pair, per port |
| line_b | input | 2*NUM_PORTS | Line-state code of the second pair, per port |
| child_in | input | NUM_PORTS | Tree role from arbitration, 1 = child |
| suspend_in | input | NUM_PORTS | Port suspended |
| raw_conn | input | NUM_PORTS | Unfiltered connect detector |
| raw_bias | input | NUM_PORTS | Unfiltered cable-bias detector |
| peer_speed | input | 3*NUM_PORTS | Peer speed code, per port |
| int_en_in | input | NUM_PORTS | Interrupt-enable bit, per port |
| fault_in | input | NUM_PORTS | Fault bit, per port |
| port_disabled | output | NUM_PORTS | Disable bit of each port |
| ch_valid | output | 1 | Child/parent role is valid |
| speed_valid | output | 1 | Peer speed is valid |

## Verification
A bus reset can arrive in the same cycle as a tree-ID or self-ID completion strobe, or in the same cycle as a host write to a disable bit. The bench drives each of these pairs in a single cycle. It expects the validity flag to end up low, because the bus reset wins. It also expects the written disable value to stay in place, because a bus reset never touches that bit. Random reads across pages, ports and addresses are then compared with a bench model while the line, role and speed inputs change on every cycle.

// File: rtl/port_status_pkg.sv
package port_status_pkg;

    typedef enum logic [1:0] {
        LS_INVALID = 2'b00,
        LS_ONE     = 2'b01,
        LS_ZERO    = 2'b10,
        LS_HIGHZ   = 2'b11
    } line_state_e;

    localparam logic [2:0] SPD_S100 = 3'b000;
    localparam logic [2:0] SPD_S200 = 3'b001;
    localparam logic [2:0] SPD_S400 = 3'b010;

    localparam logic [2:0] PAGE_PORT   = 3'd0;
    localparam logic [3:0] ADDR_STATUS = 4'b1000;
    localparam logic [3:0] ADDR_SPEED  = 4'b1001;

    typedef struct packed {
        logic [1:0] a_line;
        logic [1:0] b_line;
        logic       child;
        logic       conn;
        logic       bias;
        logic       dis;
    } status_reg_t;

    typedef struct packed {
        logic [2:0] speed;
        logic       int_en;
        logic       fault;
        logic [2:0] rsvd;
    } speed_reg_t;

    typedef struct packed {
        status_reg_t st;
        speed_reg_t  sp;
    } port_view_t;

    function automatic logic report_child(input logic child, input logic conn,
                                          input logic dis, input logic susp);
        return child | ~conn | dis | susp;
    endfunction

endpackage

// File: rtl/psp_debounce.sv
module psp_debounce #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(LIMIT + 1);

    logic          raw_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
            cnt   <= '0;
            level <= 1'b0;
        end else begin
            raw_q <= raw;
            if (raw != raw_q) begin
                cnt <= '0;
            end else if (raw_q != level) begin
                if (cnt == CW'(LIMIT - 1)) begin
                    level <= raw_q;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    // R6 R7
    level_move_chk: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |-> ($past(cnt) == CW'(LIMIT - 1) && $past(raw) == level));

endmodule

// File: rtl/psp_valid_flag.sv
module psp_valid_flag (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (clr) flag <= 1'b0;
        else if (set) flag <= 1'b1;
    end

    // R9 R10
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag);

    // R9 R10
    set_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (set && !clr) |=> flag);

endmodule

// File: rtl/psp_port_slot.sv
module psp_port_slot
    import port_status_pkg::*;
#(
    parameter int CON_LIMIT  = 16,
    parameter int BIAS_LIMIT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] a_line,
    input  logic [1:0] b_line,
    input  logic       child_in,
    input  logic       suspend_in,
    input  logic       raw_conn,
    input  logic       raw_bias,
    input  logic [2:0] speed_in,
    input  logic       int_en_in,
    input  logic       fault_in,
    input  logic       dis_we,
    input  logic       dis_wd,
    output logic       dis,
    output port_view_t view
);
    logic conn_level;
    logic bias_level;

    psp_debounce #(.LIMIT(CON_LIMIT)) u_conn_db (
        .clk(clk), .rst(rst), .raw(raw_conn), .level(conn_level)
    );

    psp_debounce #(.LIMIT(BIAS_LIMIT)) u_bias_db (
        .clk(clk), .rst(rst), .raw(raw_bias), .level(bias_level)
    );

    always_ff @(posedge clk) begin
        if (rst)         dis <= 1'b0;
        else if (dis_we) dis <= dis_wd;
    end

    always_comb begin
        view.st.a_line = a_line;
        view.st.b_line = b_line;
        view.st.child  = report_child(child_in, conn_level, dis, suspend_in);
        view.st.conn   = conn_level;
        view.st.bias   = bias_level;
        view.st.dis    = dis;
        view.sp.speed  = speed_in;
        view.sp.int_en = int_en_in;
        view.sp.fault  = fault_in;
        view.sp.rsvd   = 3'b000;
    end

    // R8
    dis_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dis_we |=> $stable(dis));

endmodule

// File: rtl/port_status_page.sv
module port_status_page
    import port_status_pkg::*;
#(
    parameter int NUM_PORTS  = 3,
    parameter int PORT_W     = 4,
    parameter int PAGE_W     = 3,
    parameter int CON_LIMIT  = 17050000,
    parameter int BIAS_LIMIT = 2600
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_reset,
    input  logic                   tree_id_done,
    input  logic                   self_id_done,
    input  logic [PAGE_W-1:0]      sel_page,
    input  logic [PORT_W-1:0]      sel_port,
    input  logic [3:0]             reg_addr,
    input  logic                   rd_en,
    output logic [7:0]             rd_data,
    input  logic                   wr_en,
    input  logic [7:0]             wr_data,
    input  logic [2*NUM_PORTS-1:0] line_a,
    input  logic [2*NUM_PORTS-1:0] line_b,
    input  logic [NUM_PORTS-1:0]   child_in,
    input  logic [NUM_PORTS-1:0]   suspend_in,
    input  logic [NUM_PORTS-1:0]   raw_conn,
    input  logic [NUM_PORTS-1:0]   raw_bias,
    input  logic [3*NUM_PORTS-1:0] peer_speed,
    input  logic [NUM_PORTS-1:0]   int_en_in,
    input  logic [NUM_PORTS-1:0]   fault_in,
    output logic [NUM_PORTS-1:0]   port_disabled,
    output logic                   ch_valid,
    output logic                   speed_valid
);
    localparam logic [PORT_W:0] PORT_LIMIT = (PORT_W + 1)'(NUM_PORTS);

    port_view_t             views [NUM_PORTS];
    port_view_t             pick;
    logic [NUM_PORTS-1:0]   dis_we;
    logic                   page_hit;
    logic                   port_ok;

    assign page_hit = (sel_page == PAGE_W'(PAGE_PORT));
    assign port_ok  = ({1'b0, sel_port} < PORT_LIMIT);

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        assign dis_we[g] = wr_en && page_hit && (sel_port == PORT_W'(g))
                           && (reg_addr == ADDR_STATUS);

        psp_port_slot #(
            .CON_LIMIT (CON_LIMIT),
            .BIAS_LIMIT(BIAS_LIMIT)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .a_line    (line_a[2*g +: 2]),
            .b_line    (line_b[2*g +: 2]),
            .child_in  (child_in[g]),
            .suspend_in(suspend_in[g]),
            .raw_conn  (raw_conn[g]),
            .raw_bias  (raw_bias[g]),
            .speed_in  (peer_speed[3*g +: 3]),
            .int_en_in (int_en_in[g]),
            .fault_in  (fault_in[g]),
            .dis_we    (dis_we[g]),
            .dis_wd    (wr_data[0]),
            .dis       (port_disabled[g]),
            .view      (views[g])
        );
    end

    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (sel_port == PORT_W'(i)) pick = views[i];
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_en && page_hit && port_ok) begin
            case (reg_addr)
                ADDR_STATUS: rd_data = pick.st;
                ADDR_SPEED:  rd_data = pick.sp;
                default:     rd_data = 8'h00;
            endcase
        end
    end

    psp_valid_flag u_ch_valid (
        .clk(clk), .rst(rst), .clr(bus_reset), .set(tree_id_done), .flag(ch_valid)
    );

    psp_valid_flag u_speed_valid (
        .clk(clk), .rst(rst), .clr(bus_reset), .set(self_id_done), .flag(speed_valid)
    );

    // R2
    unimpl_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !port_ok |-> (rd_data == 8'h00));

    // R2
    unimpl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !port_ok) |=> $stable(port_disabled));

    // R5
    child_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && page_hit && port_ok && reg_addr == ADDR_STATUS && rd_data[0]) |-> rd_data[3]);

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[3:1] != 3'b100) |-> (rd_data == 8'h00));

endmodule

// File: tb/port_status_page_tb.sv
module port_status_page_tb;
    localparam int NP = 3;
    localparam int CL = 20;
    localparam int BL = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_reset = 0, tree_id_done = 0, self_id_done = 0;
    logic [2:0] sel_page = 0;
    logic [2:0] sel_port = 0;
    logic [3:0] reg_addr = 0;
    logic rd_en = 0, wr_en = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic [2*NP-1:0] line_a = 0, line_b = 0;
    logic [NP-1:0] child_in = 0, suspend_in = 0, raw_conn = 0, raw_bias = 0;
    logic [NP-1:0] int_en_in = 0, fault_in = 0, port_disabled;
    logic [3*NP-1:0] peer_speed = 0;
    logic ch_valid, speed_valid;

    int n_chk = 0, n_fail = 0;

    logic [1:0] m_a [NP], m_b [NP];
    logic [2:0] m_spd [NP];
    logic m_child [NP], m_susp [NP], m_con [NP], m_bias [NP], m_int [NP], m_flt [NP], m_dis [NP];

    always #10 clk = ~clk;

    port_status_page #(.NUM_PORTS(NP), .PORT_W(3), .PAGE_W(3),
                       .CON_LIMIT(CL), .BIAS_LIMIT(BL)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [2:0] pg, input logic [2:0] pt,
                                            input logic [3:0] ad, input logic rd);
        logic ch;
        if (!rd || pg != 0 || pt >= NP) return 8'h00;
        ch = m_child[pt] | ~m_con[pt] | m_dis[pt] | m_susp[pt];
        if (ad == 4'b1000) return {m_a[pt], m_b[pt], ch, m_con[pt], m_bias[pt], m_dis[pt]};
        if (ad == 4'b1001) return {m_spd[pt], m_int[pt], m_flt[pt], 3'b000};
        return 8'h00;
    endfunction

    task automatic apply();
        for (int i = 0; i < NP; i++) begin
            line_a[2*i +: 2] = m_a[i];
            line_b[2*i +: 2] = m_b[i];
            peer_speed[3*i +: 3] = m_spd[i];
            child_in[i] = m_child[i];
            suspend_in[i] = m_susp[i];
            int_en_in[i] = m_int[i];
            fault_in[i] = m_flt[i];
        end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] pt, input logic [3:0] ad);
        sel_page = 0; sel_port = pt; reg_addr = ad; rd_en = 1;
        #1 chk(req, rd_data, exp_read(0, pt, ad, 1'b1));
    endtask

    task automatic do_write(input logic [2:0] pg, input logic [2:0] pt,
                            input logic [3:0] ad, input logic [7:0] d);
        sel_page = pg; sel_port = pt; reg_addr = ad; wr_data = d; wr_en = 1;
        @(posedge clk);
        if (pg == 0 && pt < NP && ad == 4'b1000) m_dis[pt] = d[0];
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NP; i++) begin
            m_a[i] = 0; m_b[i] = 0; m_spd[i] = 0; m_child[i] = 0; m_susp[i] = 0;
            m_con[i] = 0; m_bias[i] = 0; m_int[i] = 0; m_flt[i] = 0; m_dis[i] = 0;
        end
        apply();
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;

        // reset state
        chk("R11 reset port_disabled", port_disabled, 0);
        chk("R9 reset ch_valid", ch_valid, 0);
        chk("R10 reset speed_valid", speed_valid, 0);
        rd_chk("R6 reset conn clear", 0, 4'b1000);

        // R7 bias debounce on port 0
        raw_bias[0] = 1;
        repeat (BL) @(posedge clk);
        @(negedge clk); rd_chk("R7 bias before limit", 0, 4'b1000);
        @(posedge clk); @(negedge clk);
        m_bias[0] = 1; rd_chk("R7 bias after limit", 0, 4'b1000);

        // R6 conn debounce with restart on port 1
        raw_conn[1] = 1;
        repeat (15) @(posedge clk);
        @(negedge clk); raw_conn[1] = 0;
        @(posedge clk); @(negedge clk); raw_conn[1] = 1;
        repeat (15) @(posedge clk);
        @(negedge clk); rd_chk("R6 conn restarted by glitch", 1, 4'b1000);
        repeat (5) @(posedge clk);
        @(negedge clk); rd_chk("R6 conn before limit", 1, 4'b1000);
        @(posedge clk); @(negedge clk);
        m_con[1] = 1; rd_chk("R6 conn after limit", 1, 4'b1000);

        // R8 write dis, R5 child forced
        do_write(0, 1, 4'b1000, 8'hFF);
        chk("R11 port_disabled mirrors", port_disabled, 3'b010);
        m_child[1] = 0; apply();
        rd_chk("R5 disabled reads child", 1, 4'b1000);

        // same-cycle: bus reset with tree-id done and dis write
        tree_id_done = 1; self_id_done = 1;
        @(posedge clk); @(negedge clk);
        tree_id_done = 0; self_id_done = 0;
        chk("R9 tree id sets valid", ch_valid, 1);
        chk("R10 self id sets valid", speed_valid, 1);
        bus_reset = 1; tree_id_done = 1;
        sel_page = 0; sel_port = 1; reg_addr = 4'b1000; wr_data = 8'h00; wr_en = 1;
        @(posedge clk); m_dis[1] = 0;
        @(negedge clk);
        bus_reset = 0; tree_id_done = 0; wr_en = 0;
        chk("R9 bus reset wins over tree id", ch_valid, 0);
        chk("R10 bus reset clears speed valid", speed_valid, 0);
        chk("R8 write with bus reset lands", port_disabled, 3'b000);
        rd_chk("R6 conn kept over bus reset", 1, 4'b1000);
        do_write(0, 2, 4'b1000, 8'h01);
        bus_reset = 1;
        @(posedge clk); @(negedge clk); bus_reset = 0;
        chk("R8 bus reset keeps dis", port_disabled, 3'b100);

        // R2 / R8 ignored writes
        do_write(0, 5, 4'b1000, 8'h01);
        chk("R2 unimpl write ignored", port_disabled, 3'b100);
        do_write(0, 0, 4'b1001, 8'hFF);
        chk("R8 write to 1001 ignored", port_disabled, 3'b100);
        do_write(0, 0, 4'b1000, 8'hFE);
        chk("R8 only bit0 written", port_disabled, 3'b100);
        do_write(1, 0, 4'b1000, 8'h01);
        chk("R1 nonzero page write ignored", port_disabled, 3'b100);

        // settle random conn/bias on all ports
        for (int i = 0; i < NP; i++) begin
            raw_conn[i] = 1'($urandom); raw_bias[i] = 1'($urandom);
        end
        repeat (CL + 5) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin m_con[i] = raw_conn[i]; m_bias[i] = raw_bias[i]; end

        // random reads and writes
        for (int it = 0; it < 400; it++) begin
            logic [2:0] pg, pt; logic [3:0] ad; logic rd;
            for (int i = 0; i < NP; i++) begin
                m_a[i] = 2'($urandom); m_b[i] = 2'($urandom); m_spd[i] = 3'($urandom);
                m_child[i] = 1'($urandom); m_susp[i] = ($urandom % 4 == 0);
                m_int[i] = 1'($urandom); m_flt[i] = 1'($urandom);
            end
            apply();
            pg = ($urandom % 5 == 0) ? 3'($urandom) : 3'd0;
            pt = 3'($urandom % 5);
            ad = ($urandom % 2 == 0) ? 4'b1000 + 4'($urandom % 2) : 4'($urandom);
            rd = ($urandom % 8 != 0);
            sel_page = pg; sel_port = pt; reg_addr = ad; rd_en = rd;
            #1;
            if (pt >= NP) chk("R2 unimpl port reads zero", rd_data, exp_read(pg, pt, ad, rd));
            else if (pg != 0 || !rd || ad[3:1] != 3'b100)
                chk("R1 window decode", rd_data, exp_read(pg, pt, ad, rd));
            else if (ad == 4'b1000) chk("R3 R5 status layout", rd_data, exp_read(pg, pt, ad, rd));
            else chk("R4 speed layout", rd_data, exp_read(pg, pt, ad, rd));
            if ($urandom % 6 == 0) begin
                rd_en = 0;
                do_write(pg, pt, ad, 8'($urandom));
                chk("R8 R11 random write", port_disabled, {m_dis[2], m_dis[1], m_dis[0]});
            end else begin
                @(negedge clk);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule